// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block picks a single winner whenever several DMA channels ask for service in the same cycle. A two-bit mode input selects one of four priority schemes. Two schemes use a fixed ranking. The other two rotate priority: one rotates all channels, and the other rotates only the channels flagged in a per-channel mask. Once a grant is issued it stays in place until the granted channel pulses the transfer-complete strobe. Only then can the rotation advance and a fresh arbitration follow.

The controller has two named states. `ST_IDLE` means no grant is active. `ST_BUSY` means one channel owns the transfer.

- The transition ARBITRATE (`ST_IDLE` → `ST_BUSY`) is taken at a clock edge where any request is present. It registers the winner as a one-hot grant.
- The transition RELEASE (`ST_BUSY` → `ST_IDLE`) is taken at a clock edge where `xfer_done` is high. It clears the grant.
- The self-loop WAIT (`ST_IDLE`) applies while no channel requests.
- The self-loop HOLD (`ST_BUSY`) applies while the transfer is still running.

A separate rotor keeps the rotation pointer, which names the channel at the head of the round-robin order. The rotor returns the pointer to its reset value whenever the mode input changes.

Top module: `dma_prio_arb`

## Requirements
- R1: `grant` is zero or one-hot, `grant_vld` is high exactly when `grant` is non-zero, and a newly issued grant always names a channel that was requesting at the issuing edge.
- R2: In `ST_IDLE` with `req` all zero, the next cycle still has `grant_vld` low and `grant` equal to 4'b0000.
- R3: Mode 2'b00 ranks channel 0 highest, then 1, then 2, then 3 (bit i of `req` and `grant` is channel i).
- R4: Mode 2'b01 ranks channel 0 highest, then 2, then 3, then 1.
- R5: Mode 2'b11 is the all-channel rotation. After reset the order is 0 > 1 > 2 > 3. When granted channel c completes, the order becomes c+1, c+2, c+3 (modulo 4), with c last.
- R6: Mode 2'b10 is the selective rotation. Channels with their `rr_mask` bit set rotate among themselves, in circular order starting at the pointer, and rank above every unmasked channel. Unmasked channels keep index order among themselves.
- R7: The pointer moves only when `xfer_done` is high in `ST_BUSY` and the granted channel rotates in the current mode. In that case it becomes the granted index plus one, modulo 4. A strobe in `ST_IDLE`, a strobe in a fixed mode, and a strobe from an unmasked channel in mode 2'b10 all leave the pointer unchanged.
- R8: While in `ST_BUSY` without `xfer_done`, `grant` holds its value whatever `req` does. The edge that samples `xfer_done` high clears `grant`, and the earliest following grant appears one edge later.
- R9: In any cycle where `mode` differs from its value in the previous cycle (or from 2'b00 in the first cycle after reset), arbitration uses the reset order, and the pointer is cleared at that edge. This takes precedence over an advance in the same cycle.
- R10: While `rst_n` is low, `grant` is 4'b0000 and `grant_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH (4) | Per-channel service request, bit i is channel i |
| mode | input | 2 | Priority scheme: 00 fixed A, 01 fixed B, 10 selective rotation, 11 full rotation |
| rr_mask | input | NCH (4) | Channels that take part in the selective rotation |
| xfer_done | input | 1 | Transfer-complete strobe for the granted channel |
| grant | output | NCH (4) | One-hot registered grant |
| grant_vld | output | 1 | A grant is active |

## Verification
Each fixed mode is driven with request sets whose winners differ between the two fixed orders. For example, channels 1 and 3 together make channel 1 the winner in one fixed order and channel 3 the winner in the other.

Rotation modes are run with every channel requesting continuously, so that the sequence of grants exposes the pointer's movement. Runs with only unmasked channels requesting, and with strobes sent while nothing is granted, show whether the pointer moves when it must not.

Request changes during a held transfer, and mode switches in the middle of a rotation, separate a correct hold and a correct pointer reset from an early re-arbitration. A pseudo-random stretch that mixes all inputs finishes the run.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        MODE_FIX_A  = 2'b00,
        MODE_FIX_B  = 2'b01,
        MODE_SEL_RR = 2'b10,
        MODE_ALL_RR = 2'b11
    } prio_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dma_arb_rotor.sv
module dma_arb_rotor
    import dma_arb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  prio_mode_e      mode,
    input  logic            advance,
    input  logic [IDXW-1:0] done_idx,
    output logic [IDXW-1:0] ptr_eff
);
    logic [IDXW-1:0] ptr_q;
    prio_mode_e      mode_q;
    logic            mode_chg;
    logic [IDXW-1:0] ptr_inc;

    assign mode_chg = (mode != mode_q);
    assign ptr_eff  = mode_chg ? '0 : ptr_q;
    assign ptr_inc  = (done_idx == IDXW'(NCH - 1)) ? '0 : done_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mode_q <= MODE_FIX_A;
        end else begin
            mode_q <= mode;
            if (mode_chg)
                ptr_q <= '0;
            else if (advance)
                ptr_q <= ptr_inc;
        end
    end
endmodule

// File: rtl/dma_arb_rank.sv
module dma_arb_rank
    import dma_arb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int IDXW = 2,
    parameter int RW   = 3
) (
    input  prio_mode_e               mode,
    input  logic [NCH-1:0]           rr_mask,
    input  logic [IDXW-1:0]          ptr,
    output logic [NCH-1:0][RW-1:0]   rank_o
);
    logic [RW-1:0] ptr_w;
    assign ptr_w = {1'b0, ptr};

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam logic [RW-1:0] CI   = RW'(i);
        localparam logic [RW-1:0] FIXB = (i == 0) ? RW'(0) :
                                         (i == 1) ? RW'(NCH - 1) : RW'(i - 1);
        logic [RW-1:0] rot;

        always_comb begin
            rot = (CI >= ptr_w) ? (CI - ptr_w) : (CI + RW'(NCH) - ptr_w);
            unique case (mode)
                MODE_FIX_A:  rank_o[i] = CI;
                MODE_FIX_B:  rank_o[i] = FIXB;
                MODE_ALL_RR: rank_o[i] = rot;
                MODE_SEL_RR: rank_o[i] = rr_mask[i] ? rot : (RW'(NCH) + CI);
                default:     rank_o[i] = CI;
            endcase
        end
    end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NCH  = 4,
    parameter int IDXW = 2,
    parameter int RW   = 3
) (
    input  logic [NCH-1:0]          req,
    input  logic [NCH-1:0][RW-1:0]  rank_i,
    output logic [NCH-1:0]          win_oh,
    output logic [IDXW-1:0]         win_idx,
    output logic                    win_any
);
    logic [RW-1:0] best;

    always_comb begin
        best    = '1;
        win_any = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && (!win_any || rank_i[i] < best)) begin
                best    = rank_i[i];
                win_idx = IDXW'(i);
                win_any = 1'b1;
            end
        end
        win_oh = win_any ? (NCH'(1) << win_idx) : '0;
    end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [1:0]     mode,
    input  logic [NCH-1:0] rr_mask,
    input  logic           xfer_done,
    output logic [NCH-1:0] grant,
    output logic           grant_vld
);
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int RW   = IDXW + 1;

    prio_mode_e              mode_e;
    arb_state_e              state_q, state_d;
    logic [IDXW-1:0]         ptr_eff;
    logic [NCH-1:0][RW-1:0]  ranks;
    logic [NCH-1:0]          win_oh;
    logic [IDXW-1:0]         win_idx;
    logic                    win_any;
    logic [NCH-1:0]          grant_q;
    logic [IDXW-1:0]         gidx_q;
    logic                    rotate_adv;

    assign mode_e = prio_mode_e'(mode);

    dma_arb_rotor #(.NCH(NCH), .IDXW(IDXW)) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .advance  (rotate_adv),
        .done_idx (gidx_q),
        .ptr_eff  (ptr_eff)
    );

    dma_arb_rank #(.NCH(NCH), .IDXW(IDXW), .RW(RW)) u_rank (
        .mode    (mode_e),
        .rr_mask (rr_mask),
        .ptr     (ptr_eff),
        .rank_o  (ranks)
    );

    dma_arb_pick #(.NCH(NCH), .IDXW(IDXW), .RW(RW)) u_pick (
        .req     (req),
        .rank_i  (ranks),
        .win_oh  (win_oh),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    // Pointer advance: only on completion of a channel that rotates in this mode
    always_comb begin
        rotate_adv = 1'b0;
        if (state_q == ST_BUSY && xfer_done) begin
            unique case (mode_e)
                MODE_ALL_RR: rotate_adv = 1'b1;
                MODE_SEL_RR: rotate_adv = rr_mask[gidx_q];
                default:     rotate_adv = 1'b0;
            endcase
        end
    end

    // Next-state: WAIT / ARBITRATE / HOLD / RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_any)   state_d = ST_BUSY;
            ST_BUSY: if (xfer_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            gidx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (win_any) begin
                    grant_q <= win_oh;
                    gidx_q  <= win_idx;
                end
                ST_BUSY: if (xfer_done) grant_q <= '0;
                default: grant_q <= '0;
            endcase
        end
    end

    assign grant     = grant_q;
    assign grant_vld = (state_q == ST_BUSY);
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req,
    input logic [1:0]     mode,
    input logic           xfer_done,
    input logic [NCH-1:0] grant,
    input logic           grant_vld
);
    function automatic logic [NCH-1:0] first_b(input logic [NCH-1:0] r);
        logic [NCH-1:0] g;
        g = '0;
        if (r[0]) g[0] = 1'b1;
        else begin
            for (int k = NCH - 1; k >= 1; k--) begin
                if (k == 1) begin
                    if (r[1] && g == '0) g[1] = 1'b1;
                end
            end
            for (int k = NCH - 1; k >= 2; k--)
                if (r[k]) g = NCH'(1) << k;
            if (g == '0 && r[1]) g[1] = 1'b1;
        end
        return g;
    endfunction

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_vld == (grant != '0)));

    a_r1_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && req != '0) |=> (grant & $past(req)) != '0);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && req == '0) |=> !grant_vld);

    a_r3_fixed_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && req != '0 && mode == 2'b00) |=> grant == ($past(req) & (~$past(req) + 1'b1)));

    a_r4_fixed_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && req != '0 && mode == 2'b01) |=> grant == first_b($past(req)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !xfer_done) |=> grant_vld && $stable(grant));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && xfer_done) |=> !grant_vld);

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (grant == '0 && !grant_vld));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .mode      (mode),
    .xfer_done (xfer_done),
    .grant     (grant),
    .grant_vld (grant_vld)
);

// File: tb/dma_prio_arb_test.sv
module dma_prio_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [1:0] mode = '0;
    logic [3:0] rr_mask = '0;
    logic       xfer_done = 1'b0;
    logic [3:0] grant;
    logic       grant_vld;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_tag = "R10";

    // reference model state
    int   m_busy = 0;
    int   m_gidx = 0;
    int   m_ptr = 0;
    int   m_mprev = 0;
    logic [3:0] m_grant = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_prio_arb #(.NCH(4)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .mode      (mode),
        .rr_mask   (rr_mask),
        .xfer_done (xfer_done),
        .grant     (grant),
        .grant_vld (grant_vld)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int order[$];
        int p;
        int m;
        if (!rst_n) begin
            m_busy = 0; m_gidx = 0; m_ptr = 0; m_mprev = 0; m_grant = '0;
        end else begin
            m = int'(mode);
            p = (m != m_mprev) ? 0 : m_ptr;
            if (m_busy != 0) begin
                if (xfer_done) begin
                    if (m != m_mprev) p = 0;
                    else if (m == 3 || (m == 2 && rr_mask[m_gidx])) p = (m_gidx + 1) % 4;
                    m_busy = 0;
                    m_grant = '0;
                end
            end else if (req != '0) begin
                order.delete();
                case (m)
                    0: order = '{0, 1, 2, 3};
                    1: order = '{0, 2, 3, 1};
                    3: for (int k = 0; k < 4; k++) order.push_back((p + k) % 4);
                    default: begin
                        for (int k = 0; k < 4; k++)
                            if (rr_mask[(p + k) % 4]) order.push_back((p + k) % 4);
                        for (int k = 0; k < 4; k++)
                            if (!rr_mask[k]) order.push_back(k);
                    end
                endcase
                foreach (order[j]) begin
                    if (m_busy == 0 && req[order[j]]) begin
                        m_busy = 1;
                        m_gidx = order[j];
                        m_grant = 4'b0001 << order[j];
                    end
                end
            end
            m_ptr = p;
            m_mprev = m;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (grant !== m_grant || grant_vld !== (m_busy != 0)) begin
            miscompares++;
            $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
                     cur_tag, grant, grant_vld, m_grant, m_busy != 0);
        end
        if (cycles >= WATCHDOG) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic run(input logic [3:0] r, input logic [1:0] m, input logic [3:0] msk,
                       input int n, input int dper, input string tag);
        for (int k = 0; k < n; k++) begin
            cur_tag   = tag;
            req       = r;
            mode      = m;
            rr_mask   = msk;
            xfer_done = (dper > 0) && (k % dper == dper - 1);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: no requests
        run(4'b0000, 2'b00, 4'b0000, 4, 0, "R2");
        // R3: fixed order A
        run(4'b1111, 2'b00, 4'b0000, 4, 2, "R3");
        run(4'b1110, 2'b00, 4'b0000, 4, 2, "R3");
        run(4'b1100, 2'b00, 4'b0000, 4, 2, "R3");
        run(4'b1010, 2'b00, 4'b0000, 4, 2, "R3");
        run(4'b1000, 2'b00, 4'b0000, 4, 2, "R3");
        // R4: fixed order B
        run(4'b1010, 2'b01, 4'b0000, 4, 2, "R4");
        run(4'b1110, 2'b01, 4'b0000, 4, 2, "R4");
        run(4'b0011, 2'b01, 4'b0000, 4, 2, "R4");
        run(4'b0010, 2'b01, 4'b0000, 4, 2, "R4");
        run(4'b1011, 2'b01, 4'b0000, 4, 2, "R4");
        // R5: full rotation
        run(4'b1111, 2'b11, 4'b0000, 24, 3, "R5");
        run(4'b1011, 2'b11, 4'b0000, 18, 3, "R5");
        // R6: selective rotation
        run(4'b1111, 2'b10, 4'b1010, 20, 2, "R6");
        run(4'b1111, 2'b10, 4'b0110, 20, 3, "R6");
        run(4'b1001, 2'b10, 4'b0110, 10, 2, "R6");
        run(4'b1111, 2'b10, 4'b0101, 20, 2, "R6");
        // R7: strobes that must not move the pointer
        run(4'b0000, 2'b11, 4'b0000, 4, 1, "R7");
        run(4'b1111, 2'b11, 4'b0000, 12, 3, "R7");
        run(4'b0000, 2'b11, 4'b0000, 3, 1, "R7");
        run(4'b1111, 2'b11, 4'b0000, 9, 3, "R7");
        run(4'b1100, 2'b10, 4'b0011, 8, 2, "R7");
        run(4'b1111, 2'b10, 4'b0011, 12, 2, "R7");
        // R8: grant held while requests change
        run(4'b0100, 2'b00, 4'b0000, 1, 0, "R8");
        run(4'b0001, 2'b00, 4'b0000, 2, 0, "R8");
        run(4'b1111, 2'b00, 4'b0000, 2, 0, "R8");
        run(4'b0000, 2'b00, 4'b0000, 2, 0, "R8");
        run(4'b0001, 2'b00, 4'b0000, 1, 1, "R8");
        run(4'b0001, 2'b00, 4'b0000, 4, 2, "R8");
        // R9: mode changes mid-rotation
        run(4'b1111, 2'b11, 4'b0000, 7, 2, "R9");
        run(4'b1111, 2'b10, 4'b1111, 1, 1, "R9");
        run(4'b1111, 2'b10, 4'b1111, 6, 2, "R9");
        run(4'b1111, 2'b11, 4'b0000, 5, 2, "R9");
        run(4'b1111, 2'b01, 4'b0000, 1, 1, "R9");
        run(4'b1111, 2'b11, 4'b0000, 6, 2, "R9");
        // R1: mixed pseudo-random stimulus
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cur_tag   = "R1";
            req       = lfsr[3:0];
            mode      = (lfsr[15:13] == 3'b000) ? lfsr[5:4] : mode;
            rr_mask   = lfsr[9:6];
            xfer_done = lfsr[11] & lfsr[12];
            @(negedge clk);
        end
        // R10: reset in the middle of a grant
        run(4'b1111, 2'b00, 4'b0000, 2, 0, "R10");
        cur_tag = "R10";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run(4'b0000, 2'b00, 4'b0000, 2, 0, "R10");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule